// File: doc/BRIEF.md
# Memory-Mapped Word FIFO with Fault Flags

This block is a 64-deep, 32-bit word FIFO that software or a DMA-style master reaches through a small register window on a simple 32-bit bus. The bus carries a byte address, one write strobe, one read strobe and four byte enables. Writing the data register pushes a word and reading it pops one. The other registers of the window give access to a status word, a flush control, a programmable watermark level, and the two storage pointers.

The bus has no back-pressure. Every access completes in the cycle its strobe is high, and the FIFO never stalls a master. Read data arrives one cycle after the read strobe, and `bus_rvalid` marks it; `bus_rdata` then holds until the next read. Faults are reported rather than throttled. Popping an empty FIFO, pushing a full one, or touching the data register with a partial set of byte enables leaves the storage untouched and latches a sticky fault. A summary error bit gathers all these faults, and software clears it by writing 1 to it once the cause has gone.

Top module: `mmfifo_window`

## Requirements
- R1: A write with all byte enables to offset 0x3C pushes the word. A read of 0x3C pops the oldest word in first-in first-out order. Every read returns its data one cycle after the strobe, and `bus_rvalid` is high in exactly that cycle.
- R2: A data-register access with any byte enable low moves no data and no pointer, and a read returns 0. It sets the error bit, which is bit 22 of the status word at 0x40.
- R3: A pop from an empty FIFO returns 0, leaves the read pointer unchanged, and sets sticky underflow (status bit 21) and error (bit 22).
- R4: A push into a full FIFO drops the word, leaves the write pointer unchanged, and sets sticky overflow (status bit 20) and error (bit 22).
- R5: Status bit 16 is high exactly when the FIFO holds no words, and bit 19 is high exactly when it holds 64 words.
- R6: The watermark register at 0x48 reads back its low 7 bits. Status bit 18 is high when the word count is at or above it, and bit 17 is high when the count is at or below it.
- R7: Writing 1 to status bit 22 clears the byte-enable fault. It clears underflow only if the FIFO is not empty, and overflow only if it is not full. The error bit stays high while any sticky fault remains.
- R8: Offsets 0x4C and 0x50 read the 6-bit read and write pointers in bits 5:0. Writes to them have no effect.
- R9: Writing 1 to bit 0 of the control register at 0x44 empties the FIFO and returns both pointers to 0.
- R10: After reset the pointers are 0, the sticky faults are clear, read data is 0, and the status word reads 0x00070000. Reserved status bits and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; ignored when `bus_wr` is high |
| bus_be | input | 4 | Byte enables; all four are required on the data register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |
| bus_rvalid | output | 1 | High in the cycle after an accepted read |

## Verification
The bench fills the FIFO through a pointer wrap and then pushes one extra word. A design that overwrote storage or advanced the write pointer would return that extra word, or lose the oldest one, when the FIFO is drained. It attempts to clear the error bit while the FIFO is still empty or still full. A design that cleared unconditionally would drop underflow or overflow too early. Partial byte-enable accesses check that a design which ignored the enables does not push or pop. Watermark settings check that the count equal to the alarm level raises both flags, which catches a strict comparison. The bench also checks that flushing or writing the pointer registers moves the pointers only as specified.

// File: rtl/mmfifo_pkg.sv
package mmfifo_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;
  localparam int BE_W   = BUS_W / 8;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_ALARM = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_RPTR  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_WPTR  = 8'h50;

  // status bit positions (lsb-0)
  localparam int ST_EMPTY = 16;
  localparam int ST_LO    = 17;
  localparam int ST_HI    = 18;
  localparam int ST_FULL  = 19;
  localparam int ST_OVF   = 20;
  localparam int ST_UDF   = 21;
  localparam int ST_ERR   = 22;

  localparam int CTL_FLUSH = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTL,
    SEL_ALARM,
    SEL_RPTR,
    SEL_WPTR
  } rsel_e;
endpackage

// File: rtl/mmfifo_decode.sv
module mmfifo_decode
  import mmfifo_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BE_W-1:0]   be,
  input  logic              wbit_err,
  input  logic              wbit_flush,
  output logic              rd_acc,
  output logic              push_req,
  output logic              pop_req,
  output logic              be_evt,
  output logic              clr_err,
  output logic              flush,
  output logic              alarm_we,
  output rsel_e             rsel
);
  logic sel_data;
  logic whole_word;

  always_comb begin
    unique case (addr)
      OFS_DATA:  rsel = SEL_DATA;
      OFS_STAT:  rsel = SEL_STAT;
      OFS_CTL:   rsel = SEL_CTL;
      OFS_ALARM: rsel = SEL_ALARM;
      OFS_RPTR:  rsel = SEL_RPTR;
      OFS_WPTR:  rsel = SEL_WPTR;
      default:   rsel = SEL_NONE;
    endcase
  end

  assign sel_data   = (rsel == SEL_DATA);
  assign whole_word = &be;
  assign rd_acc     = rd & ~wr;

  assign push_req = wr & sel_data & whole_word;
  assign pop_req  = rd_acc & sel_data & whole_word;
  assign be_evt   = (wr | rd_acc) & sel_data & ~whole_word;
  assign clr_err  = wr & (rsel == SEL_STAT) & wbit_err;
  assign flush    = wr & (rsel == SEL_CTL) & wbit_flush;
  assign alarm_we = wr & (rsel == SEL_ALARM);
endmodule

// File: rtl/mmfifo_store.sv
module mmfifo_store #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 64,
  localparam int PW    = $clog2(DEPTH),
  localparam int LW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] wr_ptr,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf_evt,
  output logic          udf_evt
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [LW-1:0] CAP  = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          do_push;
  logic          do_pop;
  logic [PW-1:0] rd_nxt;
  logic [PW-1:0] wr_nxt;

  // pointer advance: power-of-two depth wraps naturally, others compare
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign rd_nxt = rd_ptr + 1'b1;
      assign wr_nxt = wr_ptr + 1'b1;
    end else begin : g_any
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
  endgenerate

  assign full    = (level == CAP);
  assign empty   = (level == '0);
  assign do_push = push_req & ~full;
  assign do_pop  = pop_req & ~empty;
  assign ovf_evt = push_req & full;
  assign udf_evt = pop_req & empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      unique case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/mmfifo_status.sv
module mmfifo_status #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          udf_evt,
  input  logic          ovf_evt,
  input  logic          be_evt,
  input  logic          clr_err,
  input  logic          empty,
  input  logic          full,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] alarm,
  output logic          udf_q,
  output logic          ovf_q,
  output logic          be_q,
  output logic          err,
  output logic          hi,
  output logic          lo
);
  logic udf_clr;
  logic ovf_clr;

  // a fault only clears once its cause has gone away
  assign udf_clr = clr_err & ~empty;
  assign ovf_clr = clr_err & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      udf_q <= 1'b0;
      ovf_q <= 1'b0;
      be_q  <= 1'b0;
    end else begin
      udf_q <= udf_evt | (udf_q & ~udf_clr);
      ovf_q <= ovf_evt | (ovf_q & ~ovf_clr);
      be_q  <= be_evt  | (be_q  & ~clr_err);
    end
  end

  assign err = udf_q | ovf_q | be_q;
  assign hi  = (level >= alarm);
  assign lo  = (level <= alarm);
endmodule

// File: rtl/mmfifo_window.sv
module mmfifo_window
  import mmfifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;

  logic             rd_acc, push_req, pop_req, be_evt, clr_err, flush, alarm_we;
  rsel_e            rsel;
  logic [BUS_W-1:0] head;
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [LW-1:0]    level;
  logic             full, empty, ovf_evt, udf_evt;
  logic             udf_q, ovf_q, be_q, err, hi, lo;
  logic [LW-1:0]    alarm_q;
  logic [BUS_W-1:0] stat_word;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;
  logic             rvalid_q;

  mmfifo_decode u_decode (
    .addr       (bus_addr),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .be         (bus_be),
    .wbit_err   (bus_wdata[ST_ERR]),
    .wbit_flush (bus_wdata[CTL_FLUSH]),
    .rd_acc     (rd_acc),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .be_evt     (be_evt),
    .clr_err    (clr_err),
    .flush      (flush),
    .alarm_we   (alarm_we),
    .rsel       (rsel)
  );

  mmfifo_store #(.DW(BUS_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (pop_req),
    .flush    (flush),
    .wdata    (bus_wdata),
    .head     (head),
    .rd_ptr   (rd_ptr),
    .wr_ptr   (wr_ptr),
    .level    (level),
    .full     (full),
    .empty    (empty),
    .ovf_evt  (ovf_evt),
    .udf_evt  (udf_evt)
  );

  mmfifo_status #(.LW(LW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .udf_evt (udf_evt),
    .ovf_evt (ovf_evt),
    .be_evt  (be_evt),
    .clr_err (clr_err),
    .empty   (empty),
    .full    (full),
    .level   (level),
    .alarm   (alarm_q),
    .udf_q   (udf_q),
    .ovf_q   (ovf_q),
    .be_q    (be_q),
    .err     (err),
    .hi      (hi),
    .lo      (lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alarm_q <= '0;
    else if (alarm_we) alarm_q <= bus_wdata[LW-1:0];
  end

  always_comb begin
    stat_word           = '0;
    stat_word[ST_EMPTY] = empty;
    stat_word[ST_LO]    = lo;
    stat_word[ST_HI]    = hi;
    stat_word[ST_FULL]  = full;
    stat_word[ST_OVF]   = ovf_q;
    stat_word[ST_UDF]   = udf_q;
    stat_word[ST_ERR]   = err;
  end

  always_comb begin
    unique case (rsel)
      SEL_DATA:  rd_mux = pop_req ? head : '0;
      SEL_STAT:  rd_mux = stat_word;
      SEL_ALARM: rd_mux = {{(BUS_W-LW){1'b0}}, alarm_q};
      SEL_RPTR:  rd_mux = {{(BUS_W-PW){1'b0}}, rd_ptr};
      SEL_WPTR:  rd_mux = {{(BUS_W-PW){1'b0}}, wr_ptr};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/mmfifo_window_chk.sv
module mmfifo_window_chk #(
  parameter  int DEPTH = 64,
  localparam int PW    = $clog2(DEPTH),
  localparam int LW    = PW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_acc,
  input logic          bus_rvalid,
  input logic          push_req,
  input logic          pop_req,
  input logic          be_evt,
  input logic          flush,
  input logic          full,
  input logic          empty,
  input logic          udf_q,
  input logic          ovf_q,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_ptr,
  input logic [LW-1:0] level
);
  a_r1_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> bus_rvalid);
  a_r1_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !bus_rvalid);
  a_r2_partial_moves_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    be_evt |=> $stable(rd_ptr) && $stable(wr_ptr));
  a_r3_underflow_holds_rptr: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> $stable(rd_ptr) && udf_q);
  a_r4_overflow_holds_wptr: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> $stable(wr_ptr) && full && ovf_q);
  a_r5_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r5_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && (rd_ptr == '0) && (wr_ptr == '0));
endmodule

bind mmfifo_window mmfifo_window_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_acc     (rd_acc),
  .bus_rvalid (bus_rvalid),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .be_evt     (be_evt),
  .flush      (flush),
  .full       (full),
  .empty      (empty),
  .udf_q      (udf_q),
  .ovf_q      (ovf_q),
  .rd_ptr     (rd_ptr),
  .wr_ptr     (wr_ptr),
  .level      (level)
);

// File: tb/mmfifo_window_bench.sv
module mmfifo_window_bench;
  localparam logic [7:0] A_DATA = 8'h3C, A_STAT = 8'h40, A_CTL = 8'h44;
  localparam logic [7:0] A_ALRM = 8'h48, A_RPTR = 8'h4C, A_WPTR = 8'h50;
  localparam logic [31:0] S_EMPTY = 32'h1 << 16, S_LO = 32'h1 << 17;
  localparam logic [31:0] S_HI = 32'h1 << 18, S_FULL = 32'h1 << 19;
  localparam logic [31:0] S_OVF = 32'h1 << 20, S_UDF = 32'h1 << 21;
  localparam logic [31:0] S_ERR = 32'h1 << 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0, fails = 0;
  int exp_rp = 0, exp_wp = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mmfifo_window u_mmfifo_window (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'h1);
  endtask

  task automatic push(input logic [31:0] d);
    wr(A_DATA, d);
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk("R10 rdata after reset", bus_rdata, 32'h0);
    chk("R10 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
    chk_reg("R10 status after reset", A_STAT, S_EMPTY | S_LO | S_HI);
    chk_reg("R10 rptr after reset", A_RPTR, 0);
    chk_reg("R10 wptr after reset", A_WPTR, 0);
    chk_reg("R10 unmapped offset", 8'h00, 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    push(32'h1111_1111); push(32'h2222_2222); push(32'h3333_3333);
    exp_wp += 3;
    chk_reg("R5 R6 status level 3", A_STAT, S_HI);
    rd(A_DATA, v); chk("R1 pop order 1", v, 32'h1111_1111);
    rd(A_DATA, v); chk("R1 pop order 2", v, 32'h2222_2222);
    rd(A_DATA, v); chk("R1 pop order 3", v, 32'h3333_3333);
    exp_rp += 3;
    chk_reg("R5 status drained", A_STAT, S_EMPTY | S_LO | S_HI);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    wr(A_DATA, 32'h0000_DEAD, 4'b0111);
    chk_reg("R2 err after partial write", A_STAT, S_ERR | S_EMPTY | S_LO | S_HI);
    chk_reg("R2 wptr unchanged", A_WPTR, exp_wp);
    push(32'h5A5A_0001); exp_wp++;
    rd(A_DATA, v, 4'b1100);
    chk("R2 partial read data", v, 32'h0);
    chk_reg("R2 rptr unchanged", A_RPTR, exp_rp);
    rd(A_DATA, v); exp_rp++;
    chk("R2 word survives partial read", v, 32'h5A5A_0001);
    wr(A_STAT, S_ERR);
    chk_reg("R7 byte-enable fault cleared", A_STAT, S_EMPTY | S_LO | S_HI);
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    rd(A_DATA, v);
    chk("R3 empty pop data", v, 32'h0);
    chk_reg("R3 underflow status", A_STAT, S_ERR | S_UDF | S_EMPTY | S_LO | S_HI);
    chk_reg("R3 rptr held", A_RPTR, exp_rp);
    wr(A_STAT, S_ERR);
    chk_reg("R7 clear refused while empty", A_STAT, S_ERR | S_UDF | S_EMPTY | S_LO | S_HI);
    push(32'hCAFE_0001); exp_wp++;
    wr(A_STAT, S_ERR);
    chk_reg("R7 clear after refill", A_STAT, S_HI);
    rd(A_DATA, v); exp_rp++;
    chk("R1 pop after underflow", v, 32'hCAFE_0001);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    for (int i = 0; i < 64; i++) push(32'hA000_0000 + i);
    exp_wp = (exp_wp + 64) % 64;
    chk_reg("R5 full status", A_STAT, S_FULL | S_HI);
    push(32'hBADB_AD00);
    chk_reg("R4 overflow status", A_STAT, S_ERR | S_OVF | S_FULL | S_HI);
    chk_reg("R4 wptr held", A_WPTR, exp_wp);
    wr(A_STAT, S_ERR);
    chk_reg("R7 clear refused while full", A_STAT, S_ERR | S_OVF | S_FULL | S_HI);
    rd(A_DATA, v);
    chk("R4 oldest word kept", v, 32'hA000_0000);
    wr(A_STAT, S_ERR);
    chk_reg("R7 clear after drain", A_STAT, S_HI);
    for (int i = 1; i < 64; i++) begin
      rd(A_DATA, v);
      chk("R4 R1 drain order", v, 32'hA000_0000 + i);
    end
    exp_rp = (exp_rp + 64) % 64;
    chk_reg("R4 dropped word absent", A_STAT, S_EMPTY | S_LO | S_HI);
    chk_reg("R8 rptr after wrap", A_RPTR, exp_rp);
  endtask

  task automatic t_watermark();
    logic [31:0] v;
    wr(A_ALRM, 32'hFFFF_FF83);
    chk_reg("R6 alarm readback", A_ALRM, 32'h03);
    chk_reg("R6 level 0 below alarm", A_STAT, S_EMPTY | S_LO);
    push(32'h1); push(32'h2); push(32'h3); exp_wp += 3;
    chk_reg("R6 level equals alarm", A_STAT, S_HI | S_LO);
    push(32'h4); exp_wp++;
    chk_reg("R6 level above alarm", A_STAT, S_HI);
    rd(A_DATA, v); exp_rp++;
    chk_reg("R6 back to alarm level", A_STAT, S_HI | S_LO);
  endtask

  task automatic t_pointers_flush();
    wr(A_RPTR, 32'h9);
    wr(A_WPTR, 32'h21);
    chk_reg("R8 rptr ignores write", A_RPTR, exp_rp % 64);
    chk_reg("R8 wptr ignores write", A_WPTR, exp_wp % 64);
    wr(A_CTL, 32'h1);
    exp_rp = 0; exp_wp = 0;
    chk_reg("R9 rptr after flush", A_RPTR, 0);
    chk_reg("R9 wptr after flush", A_WPTR, 0);
    chk_reg("R9 status after flush", A_STAT, S_EMPTY | S_LO);
    chk_reg("R10 control reads zero", A_CTL, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_partial();
    t_underflow();
    t_overflow();
    t_watermark();
    t_pointers_flush();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule